// File: doc/BRIEF.md
# Indirect Control and Status Register Bank

This block is the host-visible register file of a network controller. The host reaches every register through two 16-bit word ports. One port holds a register pointer. The other port reads or writes whichever register the pointer currently selects. The pointer keeps its value between data accesses, so a host that parks it on the main register can poll and acknowledge events with single data accesses.

The main register combines four kinds of bit: command bits that can only be set, event bits that the host clears by writing one, a read/write interrupt enable, and read-only status. The error summary and the interrupt summary are derived from the stored bits. The ring engines report events as one-cycle pulses. The bank returns one-cycle command strobes to the engines and drives a level interrupt. The configuration registers are the init-block address, the bus-control bits, the logical address filter and the promiscuous flag. They accept writes only while the controller is stopped. A stop command overrides every other bit in the same write and also clears the bus-control register.

A parameterised counter stands in for the init-block fetch. It raises the init-done event a fixed number of cycles after an accepted init command.

Top module: `csr_bank`

## Requirements
- R1: A write to word offset 1 loads the pointer from data bits [3:0]. The pointer holds that value until the next write to offset 1. A read at offset 1 returns the pointer in bits [3:0] with zeros above. Accesses at offset 0 reach the register with index equal to the pointer, and index 0 is the main register.
- R2: After reset the main register reads 0x0004 (stopped), the pointer is 0, and all configuration registers are 0.
- R3: In the main register, INIT (bit 0), STRT (bit 1) and TDMD (bit 3) are set by writing one, and writing zero to them has no effect. INIT is accepted only while stopped, and it clears STOP. STRT clears STOP and sets TXON (bit 4) and RXON (bit 5). TDMD is accepted only when the controller is not stopped after the write, and a transmit-done event clears it.
- R4: A main-register write with STOP (bit 2) set leaves exactly 0x0004 in the main register, whatever else is in that write and whatever events arrive in that cycle. The same write clears the bus-control register.
- R5: The event inputs set TINT (9), RINT (10), MERR (11), MISS (12), CERR (13) and BABL (14), and IDON (8) is set by the init counter. Writing one clears these bits and writing zero leaves them unchanged. When an event arrives in the same cycle as a clear of its bit, the event wins. Events that arrive while stopped are ignored.
- R6: ERR (bit 15) reads as the OR of BABL, CERR, MISS and MERR. INTR (bit 7) reads as the OR of ERR, IDON, TINT and RINT.
- R7: INEA (bit 6) takes the written value on every main-register write. The interrupt output is high exactly when INTR and INEA are both set.
- R8: IDON becomes set INIT_CYCLES clock edges after the edge that accepted INIT.
- R9: Register 1 holds the init-block address bits [15:0] and register 2 holds bits [31:16]. Register 3 holds the bus-control bits [2:0], where bit 2 is byte swap. Registers 8 to 11 hold the 64-bit filter, with register 8 as bits [15:0]. Bit 15 of register 15 is the promiscuous flag. These registers are written only while STOP is set, and writes at other times are ignored. Unimplemented indices read 0.
- R10: The init, start, stop and demand strobes each pulse high for the one cycle that follows an accepted command write. A stop strobe never coincides with any other strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | Word offset: 0 selects the data port, 1 selects the pointer |
| busWe | input | 1 | Write enable for the current access |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for the current offset and pointer |
| evTint | input | 1 | Transmit-done event pulse |
| evRint | input | 1 | Receive-done event pulse |
| evMerr | input | 1 | Memory error pulse |
| evMiss | input | 1 | Missed frame pulse |
| evCerr | input | 1 | Carrier error pulse |
| evBabl | input | 1 | Babble pulse |
| cmdInit | output | 1 | Init command strobe |
| cmdStart | output | 1 | Start command strobe |
| cmdStop | output | 1 | Stop command strobe |
| cmdDemand | output | 1 | Transmit demand strobe |
| irqOut | output | 1 | Interrupt request level |
| initAddr | output | 32 | Init-block address |
| busCtl | output | 3 | Bus-control bits, bit 2 is byte swap |
| addrFilter | output | 64 | Logical address filter |
| promiscEn | output | 1 | Promiscuous enable |

## Verification
A host clear and an engine event can land on the same event bit in the same cycle. So can a stop command and any event or command. The bench forces both collisions on purpose. It writes one to TINT while it pulses the transmit-done input, and it writes STOP while it pulses the receive-done input. The first case must leave TINT set, and the second must leave exactly 0x0004. A behavioural reference model compares the read data, strobes, interrupt and configuration outputs on every clock, so the cycle that follows each collision is checked as well.

// File: rtl/csrbank_pkg.sv
package csrbank_pkg;
  localparam int REG_W = 16;
  localparam int PTR_W = 4;

  // main register bit positions
  localparam int B_INIT = 0;
  localparam int B_STRT = 1;
  localparam int B_STOP = 2;
  localparam int B_TDMD = 3;
  localparam int B_INEA = 6;
  localparam int B_IDON = 8;
  localparam int B_TINT = 9;
  localparam int B_RINT = 10;
  localparam int B_MERR = 11;
  localparam int B_MISS = 12;
  localparam int B_CERR = 13;
  localparam int B_BABL = 14;

  // strobes from the host decoder to the register datapaths
  typedef struct packed {
    logic             mainWr;
    logic             cfgWr;
    logic [PTR_W-1:0] regSel;
    logic [REG_W-1:0] wdata;
  } hostStb_t;
endpackage

// File: rtl/csrbank_ctrl.sv
module csrbank_ctrl
  import csrbank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busAddr,
  input  logic             busWe,
  input  logic [REG_W-1:0] busWdata,
  output logic [PTR_W-1:0] ptrQ,
  output hostStb_t         stb
);
  always_ff @(posedge clk) begin
    if (!rstN) ptrQ <= '0;
    else if (busWe && busAddr) ptrQ <= busWdata[PTR_W-1:0];
  end

  always_comb begin
    stb.mainWr = busWe && !busAddr && (ptrQ == '0);
    stb.cfgWr  = busWe && !busAddr && (ptrQ != '0);
    stb.regSel = ptrQ;
    stb.wdata  = busWdata;
  end
endmodule

// File: rtl/csrbank_status.sv
module csrbank_status
  import csrbank_pkg::*;
#(
  parameter int INIT_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStb_t         stb,
  input  logic             evTint,
  input  logic             evRint,
  input  logic             evMerr,
  input  logic             evMiss,
  input  logic             evCerr,
  input  logic             evBabl,
  output logic [REG_W-1:0] csr0Rd,
  output logic             stopped,
  output logic             irqOut,
  output logic             cmdInit,
  output logic             cmdStart,
  output logic             cmdStop,
  output logic             cmdDemand
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  logic stopQ, initQ, strtQ, tdmdQ, txonQ, rxonQ, ineaQ;
  logic idonQ, tintQ, rintQ, merrQ, missQ, cerrQ, bablQ;
  logic [CNT_W-1:0] cntQ;

  logic [REG_W-1:0] clr;
  logic stopW, initAcc, strtAcc, stopNext, tdmdAcc, evOn, cntDone, errB, intrB;

  always_comb begin
    clr      = stb.mainWr ? stb.wdata : '0;
    stopW    = stb.mainWr && stb.wdata[B_STOP];
    initAcc  = stb.mainWr && stb.wdata[B_INIT] && !stb.wdata[B_STOP] && stopQ;
    strtAcc  = stb.mainWr && stb.wdata[B_STRT] && !stb.wdata[B_STOP];
    stopNext = stopW || (stopQ && !initAcc && !strtAcc);
    tdmdAcc  = stb.mainWr && stb.wdata[B_TDMD] && !stopNext;
    evOn     = !stopQ;
    cntDone  = (cntQ == CNT_W'(1));
    errB     = merrQ | missQ | cerrQ | bablQ;
    intrB    = errB | idonQ | tintQ | rintQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ <= 1'b1;
      {initQ, strtQ, tdmdQ, txonQ, rxonQ, ineaQ} <= '0;
      {idonQ, tintQ, rintQ, merrQ, missQ, cerrQ, bablQ} <= '0;
      cntQ <= '0;
      {cmdInit, cmdStart, cmdStop, cmdDemand} <= '0;
    end else begin
      cmdStop   <= stopW;
      cmdInit   <= initAcc;
      cmdStart  <= strtAcc;
      cmdDemand <= tdmdAcc;
      if (stopW) begin
        stopQ <= 1'b1;
        {initQ, strtQ, tdmdQ, txonQ, rxonQ, ineaQ} <= '0;
        {idonQ, tintQ, rintQ, merrQ, missQ, cerrQ, bablQ} <= '0;
        cntQ <= '0;
      end else begin
        stopQ <= stopNext;
        initQ <= initQ | initAcc;
        strtQ <= strtQ | strtAcc;
        txonQ <= txonQ | strtAcc;
        rxonQ <= rxonQ | strtAcc;
        tdmdQ <= tdmdAcc | (tdmdQ & ~(evTint & evOn));
        if (stb.mainWr) ineaQ <= stb.wdata[B_INEA];
        idonQ <= (idonQ & ~clr[B_IDON]) | cntDone;
        tintQ <= (tintQ & ~clr[B_TINT]) | (evTint & evOn);
        rintQ <= (rintQ & ~clr[B_RINT]) | (evRint & evOn);
        merrQ <= (merrQ & ~clr[B_MERR]) | (evMerr & evOn);
        missQ <= (missQ & ~clr[B_MISS]) | (evMiss & evOn);
        cerrQ <= (cerrQ & ~clr[B_CERR]) | (evCerr & evOn);
        bablQ <= (bablQ & ~clr[B_BABL]) | (evBabl & evOn);
        if (initAcc) cntQ <= CNT_W'(INIT_CYCLES);
        else if (cntQ != '0) cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  assign csr0Rd  = {errB, bablQ, cerrQ, missQ, merrQ, rintQ, tintQ, idonQ,
                    intrB, ineaQ, rxonQ, txonQ, tdmdQ, stopQ, strtQ, initQ};
  assign stopped = stopQ;
  assign irqOut  = intrB & ineaQ;
endmodule

// File: rtl/csrbank_cfg.sv
module csrbank_cfg
  import csrbank_pkg::*;
#(
  parameter int FILT_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  hostStb_t                    stb,
  input  logic                        stopped,
  output logic [31:0]                 initAddr,
  output logic [2:0]                  busCtl,
  output logic [REG_W*FILT_WORDS-1:0] addrFilter,
  output logic                        promiscEn,
  output logic [REG_W-1:0]            cfgRd
);
  localparam int IDX_LO    = 1;
  localparam int IDX_HI    = 2;
  localparam int IDX_BUS   = 3;
  localparam int FILT_BASE = 8;
  localparam int IDX_PROM  = 15;

  logic cfgOk, stopW;
  logic [REG_W-1:0] loQ, hiQ;
  logic [2:0]       busQ;
  logic             promQ;
  logic [REG_W-1:0] filtQ [FILT_WORDS];

  assign cfgOk = stb.cfgWr && stopped;
  assign stopW = stb.mainWr && stb.wdata[B_STOP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loQ <= '0; hiQ <= '0; busQ <= '0; promQ <= 1'b0;
    end else begin
      if (cfgOk && int'(stb.regSel) == IDX_LO) loQ <= stb.wdata;
      if (cfgOk && int'(stb.regSel) == IDX_HI) hiQ <= stb.wdata;
      if (cfgOk && int'(stb.regSel) == IDX_PROM) promQ <= stb.wdata[REG_W-1];
      if (stopW) busQ <= '0;
      else if (cfgOk && int'(stb.regSel) == IDX_BUS) busQ <= stb.wdata[2:0];
    end
  end

  for (genvar g = 0; g < FILT_WORDS; g++) begin : gFilt
    always_ff @(posedge clk) begin
      if (!rstN) filtQ[g] <= '0;
      else if (cfgOk && int'(stb.regSel) == FILT_BASE + g) filtQ[g] <= stb.wdata;
    end
    assign addrFilter[g*REG_W +: REG_W] = filtQ[g];
  end

  always_comb begin
    cfgRd = '0;
    if (int'(stb.regSel) == IDX_LO)   cfgRd = loQ;
    if (int'(stb.regSel) == IDX_HI)   cfgRd = hiQ;
    if (int'(stb.regSel) == IDX_BUS)  cfgRd = {13'd0, busQ};
    if (int'(stb.regSel) == IDX_PROM) cfgRd = {promQ, 15'd0};
    for (int g = 0; g < FILT_WORDS; g++)
      if (int'(stb.regSel) == FILT_BASE + g) cfgRd = filtQ[g];
  end

  assign initAddr  = {hiQ, loQ};
  assign busCtl    = busQ;
  assign promiscEn = promQ;
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csrbank_pkg::*;
#(
  parameter int INIT_CYCLES = 8,
  parameter int FILT_WORDS  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busAddr,
  input  logic                        busWe,
  input  logic [15:0]                 busWdata,
  output logic [15:0]                 busRdata,
  input  logic                        evTint,
  input  logic                        evRint,
  input  logic                        evMerr,
  input  logic                        evMiss,
  input  logic                        evCerr,
  input  logic                        evBabl,
  output logic                        cmdInit,
  output logic                        cmdStart,
  output logic                        cmdStop,
  output logic                        cmdDemand,
  output logic                        irqOut,
  output logic [31:0]                 initAddr,
  output logic [2:0]                  busCtl,
  output logic [16*FILT_WORDS-1:0]    addrFilter,
  output logic                        promiscEn
);
  hostStb_t         stb;
  logic [PTR_W-1:0] ptrQ;
  logic [REG_W-1:0] csr0Val, cfgRd;
  logic             stopped;

  csrbank_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .ptrQ(ptrQ), .stb(stb)
  );

  csrbank_status #(.INIT_CYCLES(INIT_CYCLES)) status_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .evTint(evTint), .evRint(evRint), .evMerr(evMerr),
    .evMiss(evMiss), .evCerr(evCerr), .evBabl(evBabl),
    .csr0Rd(csr0Val), .stopped(stopped), .irqOut(irqOut),
    .cmdInit(cmdInit), .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdDemand(cmdDemand)
  );

  csrbank_cfg #(.FILT_WORDS(FILT_WORDS)) cfg_i (
    .clk(clk), .rstN(rstN), .stb(stb), .stopped(stopped),
    .initAddr(initAddr), .busCtl(busCtl), .addrFilter(addrFilter),
    .promiscEn(promiscEn), .cfgRd(cfgRd)
  );

  assign busRdata = busAddr ? {{(REG_W-PTR_W){1'b0}}, ptrQ}
                            : ((ptrQ == '0) ? csr0Val : cfgRd);
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int FW = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         busAddr,
  input logic         busWe,
  input logic [15:0]  busWdata,
  input logic [3:0]   ptrQ,
  input logic [15:0]  csr0Val,
  input logic         irqOut,
  input logic         cmdInit,
  input logic         cmdStart,
  input logic         cmdStop,
  input logic         cmdDemand,
  input logic [31:0]  initAddr,
  input logic [16*FW-1:0] addrFilter,
  input logic         promiscEn
);
  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && busAddr |=> ptrQ == $past(busWdata[3:0]));

  // R4
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && !busAddr && ptrQ == 4'd0 && busWdata[2] |=> csr0Val == 16'h0004);

  // R6
  err_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csr0Val[14]) |-> csr0Val[15] && csr0Val[7]);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csr0Val[6] |-> !irqOut);

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csr0Val[2] |=> $stable(initAddr) && $stable(addrFilter) && $stable(promiscEn));

  // R10
  stop_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |-> !cmdInit && !cmdStart && !cmdDemand && csr0Val == 16'h0004);
endmodule

bind csr_bank csr_bank_chk #(.FW(FILT_WORDS)) chk_i (.*);

// File: tb/csr_bank_tb.sv
`timescale 1ns/1ps
module csr_bank_tb_top;
  localparam int NCYC = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [5:0] ev = '0; // {babl,cerr,miss,merr,rint,tint}
  logic [15:0] busRdata;
  logic cmdInit, cmdStart, cmdStop, cmdDemand, irqOut, promiscEn;
  logic [31:0] initAddr;
  logic [2:0] busCtl;
  logic [63:0] addrFilter;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  csr_bank #(.INIT_CYCLES(NCYC), .FILT_WORDS(4)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata),
    .evTint(ev[0]), .evRint(ev[1]), .evMerr(ev[2]), .evMiss(ev[3]),
    .evCerr(ev[4]), .evBabl(ev[5]),
    .cmdInit(cmdInit), .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdDemand(cmdDemand),
    .irqOut(irqOut), .initAddr(initAddr), .busCtl(busCtl),
    .addrFilter(addrFilter), .promiscEn(promiscEn)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [3:0] mPtr;
  logic mStop, mInit, mStrt, mTdmd, mTxon, mRxon, mInea;
  logic mIdon, mTint, mRint, mMerr, mMiss, mCerr, mBabl, mProm;
  int mCnt;
  logic [15:0] mLo, mHi;
  logic [2:0] mBc;
  logic [63:0] mFilt;
  logic [3:0] mCmd; // {init,start,stop,demand}

  function automatic logic [15:0] mMain();
    logic err;
    err = mMerr | mMiss | mCerr | mBabl;
    return {err, mBabl, mCerr, mMiss, mMerr, mRint, mTint, mIdon,
            err | mIdon | mTint | mRint, mInea, mRxon, mTxon, mTdmd, mStop, mStrt, mInit};
  endfunction

  function automatic logic [15:0] mRead(logic a);
    if (a) return {12'd0, mPtr};
    case (mPtr)
      4'd0: return mMain();
      4'd1: return mLo;
      4'd2: return mHi;
      4'd3: return {13'd0, mBc};
      4'd8, 4'd9, 4'd10, 4'd11: return mFilt[(int'(mPtr) - 8) * 16 +: 16];
      4'd15: return {mProm, 15'd0};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] w, clr;
    logic wrM, wrC, evOk, stopHit, initOk, strtOk, newStop, demOk, done;
    if (!rstN) begin
      mPtr = 0; mStop = 1; {mInit, mStrt, mTdmd, mTxon, mRxon, mInea} = '0;
      {mIdon, mTint, mRint, mMerr, mMiss, mCerr, mBabl, mProm} = '0;
      mCnt = 0; mLo = 0; mHi = 0; mBc = 0; mFilt = 0; mCmd = 0;
    end else begin
      w = busWdata;
      wrM = busWe && !busAddr && mPtr == 0;
      wrC = busWe && !busAddr && mPtr != 0;
      evOk = !mStop;
      stopHit = wrM && w[2];
      initOk = wrM && w[0] && !w[2] && mStop;
      strtOk = wrM && w[1] && !w[2];
      if (wrC && mStop) begin
        case (mPtr)
          4'd1: mLo = w;
          4'd2: mHi = w;
          4'd3: mBc = w[2:0];
          4'd8, 4'd9, 4'd10, 4'd11: mFilt[(int'(mPtr) - 8) * 16 +: 16] = w;
          4'd15: mProm = w[15];
          default: ;
        endcase
      end
      if (stopHit) mBc = 0;
      mCmd = {initOk, strtOk, stopHit, 1'b0};
      if (stopHit) begin
        mStop = 1; {mInit, mStrt, mTdmd, mTxon, mRxon, mInea} = '0;
        {mIdon, mTint, mRint, mMerr, mMiss, mCerr, mBabl} = '0;
        mCnt = 0;
      end else begin
        clr = wrM ? w : 16'd0;
        newStop = mStop && !initOk && !strtOk;
        demOk = wrM && w[3] && !newStop;
        mCmd[0] = demOk;
        done = (mCnt == 1);
        if (initOk) mCnt = NCYC; else if (mCnt > 0) mCnt--;
        mTdmd = demOk || (mTdmd && !(ev[0] && evOk));
        mIdon = (mIdon && !clr[8]) || done;
        mTint = (mTint && !clr[9]) || (ev[0] && evOk);
        mRint = (mRint && !clr[10]) || (ev[1] && evOk);
        mMerr = (mMerr && !clr[11]) || (ev[2] && evOk);
        mMiss = (mMiss && !clr[12]) || (ev[3] && evOk);
        mCerr = (mCerr && !clr[13]) || (ev[4] && evOk);
        mBabl = (mBabl && !clr[14]) || (ev[5] && evOk);
        if (wrM) mInea = w[6];
        mInit = mInit | initOk; mStrt = mStrt | strtOk;
        mTxon = mTxon | strtOk; mRxon = mRxon | strtOk;
        mStop = newStop;
      end
      if (busWe && busAddr) mPtr = w[3:0];
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [15:0] mm;
      mm = mMain();
      chk("R1 read data vs model", busRdata, mRead(busAddr));
      chk("R7 irq vs model", irqOut, mm[7] & mm[6]);
      chk("R10 strobes vs model", {cmdInit, cmdStart, cmdStop, cmdDemand}, mCmd);
      chk("R9 config outputs vs model", {initAddr, busCtl, promiscEn}, {mHi, mLo, mBc, mProm});
      chk("R9 filter vs model", addrFilter, mFilt);
    end
  end

  task automatic cyc(logic a, logic we, logic [15:0] d, logic [5:0] e);
    @(negedge clk); #1;
    busAddr = a; busWe = we; busWdata = d; ev = e;
    @(posedge clk); #1;
  endtask
  task automatic idle(); cyc(1'b0, 1'b0, 16'd0, 6'd0); endtask
  task automatic setp(logic [3:0] p); cyc(1'b1, 1'b1, {12'd0, p}, 6'd0); endtask
  task automatic wr(logic [15:0] d); cyc(1'b0, 1'b1, d, 6'd0); endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    idle();
    // R2 reset state
    chk("R2 main after reset", busRdata, 16'h0004);
    chk("R2 config after reset", {initAddr, busCtl, promiscEn}, '0);
    cyc(1'b1, 1'b0, 16'd0, 6'd0);
    chk("R2 pointer after reset", busRdata, 16'd0);

    // R9 config writes while stopped
    setp(4'd3); wr(16'h0007);
    chk("R9 bus control written", busCtl, 3'd7);
    setp(4'd1); wr(16'h1234);
    setp(4'd2); wr(16'h00AB);
    setp(4'd9); wr(16'hBEEF);
    setp(4'd15); wr(16'h8000);
    chk("R9 init address", initAddr, 32'h00AB1234);
    chk("R9 filter word at index 9", addrFilter[31:16], 16'hBEEF);
    chk("R9 promiscuous flag", promiscEn, 1'b1);
    setp(4'd5); idle();
    chk("R9 unimplemented reads zero", busRdata, 16'd0);

    // R1 pointer holds across data accesses
    setp(4'd9); idle(); idle();
    chk("R1 data port at held pointer", busRdata, 16'hBEEF);
    cyc(1'b1, 1'b0, 16'd0, 6'd0);
    chk("R1 pointer readback", busRdata, 16'd9);

    // R5 events ignored while stopped
    setp(4'd0);
    cyc(1'b0, 1'b0, 16'd0, 6'h3F);
    chk("R5 events ignored while stopped", busRdata, 16'h0004);

    // R4 INIT with STOP reads back STOP alone and clears bus control
    wr(16'h0005);
    chk("R4 init plus stop", busRdata, 16'h0004);
    chk("R4 stop clears bus control", busCtl, 3'd0);

    // R3/R8/R10 init sequence
    wr(16'h0001);
    chk("R10 init strobe", {cmdInit, cmdStart, cmdStop, cmdDemand}, 4'b1000);
    chk("R3 init clears stop", busRdata, 16'h0001);
    n = 0;
    while (busRdata[8] == 1'b0 && n < 40) begin idle(); n++; end
    chk("R8 init done delay", n, NCYC);
    chk("R8 init done state", busRdata, 16'h0181);

    // R7 interrupt gating
    wr(16'h0042);
    chk("R3 start sets tx and rx on", busRdata, 16'h01F3);
    chk("R7 irq with INEA and INTR", irqOut, 1'b1);
    wr(16'h0140);
    chk("R5 IDON cleared by one", busRdata, 16'h0073);
    chk("R7 irq drops with INTR", irqOut, 1'b0);
    wr(16'h0000);
    chk("R3 zero write leaves commands", busRdata, 16'h0033);

    // R3 demand, cleared by transmit-done
    wr(16'h0008);
    chk("R10 demand strobe", cmdDemand, 1'b1);
    chk("R3 demand set", busRdata, 16'h003B);
    cyc(1'b0, 1'b0, 16'd0, 6'b000001);
    chk("R3 tx done clears demand", busRdata, 16'h02B3);

    // R5 clear colliding with event: event wins
    cyc(1'b0, 1'b1, 16'h0200, 6'b000001);
    chk("R5 event beats clear", busRdata, 16'h02B3);
    wr(16'h0200);
    chk("R5 clear by one", busRdata, 16'h0033);

    // R6 error summary
    cyc(1'b0, 1'b0, 16'd0, 6'b100000);
    chk("R6 babble sets ERR and INTR", busRdata, 16'hC0B3);
    wr(16'h0040);
    chk("R7 irq on error", irqOut, 1'b1);
    chk("R5 zero write keeps events", busRdata, 16'hC0F3);
    wr(16'h4040);
    chk("R6 ERR follows babble clear", busRdata, 16'h0073);

    // R9 config write ignored while running
    setp(4'd1); wr(16'hFFFF);
    chk("R9 write ignored while running", initAddr, 32'h00AB1234);

    // R4 stop with a same-cycle event
    setp(4'd0);
    cyc(1'b0, 1'b1, 16'h0004, 6'b000010);
    chk("R4 stop beats event", busRdata, 16'h0004);
    chk("R10 stop strobe alone", {cmdInit, cmdStart, cmdStop, cmdDemand}, 4'b0010);
    chk("R7 irq low after stop", irqOut, 1'b0);

    // R3 start from stopped
    wr(16'h0002);
    chk("R3 start from stopped", busRdata, 16'h0032);
    chk("R10 start strobe", cmdStart, 1'b1);
    idle(); idle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule